// File: doc/BRIEF.md
# Receive Sample Depth Reducer and Packer

This block sits in a receive data path between a decimated complex I/Q sample source and a 16-bit host-bound word stream. It takes one sample set per strobe: signed 16-bit I and Q values for each of up to two channels. It then emits a short burst of 16-bit words on a valid/ready output. A digital gain stage comes first. It shifts each sample left by a programmable amount and preserves the sign. If the result leaves the signed 16-bit range, it clamps to the nearest extreme rather than wrapping. Each shift step adds about 6 dB.

In wide mode each gained sample becomes one output word. In narrow mode only the top byte of each gained sample is kept. The I and Q bytes of a channel then share one word, so the same bus bandwidth carries twice the sample rate. The configuration is loaded through a write strobe. It is copied into each sample set as that set is accepted, so a change never splits a packed word. A sample set that arrives while earlier words are still waiting is dropped, and this raises a sticky overrun flag. A synchronous flush discards the pending words and clears the flag.

Top module: `rxpk_top`

## Requirements
- R1: After reset, pk_valid and ovr_flag are 0 and the configuration is wide mode, one channel, shift 0.
- R2: In wide single-channel mode with shift 0, one sample set yields exactly two words: I0, then Q0, each equal to the input bit for bit.
- R3: With cfg_dual=1 in wide mode, one set yields four words in the order I0, Q0, I1, Q1.
- R4: In narrow mode (cfg_narrow=1) a channel yields one word: the Q sample's bits [15:8] in word bits [15:8], and the I sample's bits [15:8] in word bits [7:0].
- R5: In narrow dual mode, a set yields two words: channel 0's word, then channel 1's word.
- R6: A shift of s (0..8) multiplies each sample by 2^s before width reduction, keeping its sign, whenever the product fits in signed 16 bits.
- R7: A shifted sample that would exceed the signed 16-bit range becomes 0x7FFF if positive or 0x8000 if negative.
- R8: A shift setting above 8 acts as 8.
- R9: While pk_valid=1 and pk_ready=0, pk_data and pk_valid stay unchanged, and no word is lost.
- R10: A smp_valid that arrives while words are pending and the last one is not being taken that cycle is dropped, and it sets ovr_flag. The flag stays set until a flush.
- R11: flush=1 discards all pending words (pk_valid falls on the next cycle) and clears ovr_flag.
- R12: A configuration write affects only sample sets accepted after it. Words already pending keep the format they were built with.
- R13: A new set is accepted without overrun in the same cycle that the last pending word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_narrow | input | 1 | 1 = 8-bit packed mode, 0 = 16-bit mode |
| cfg_dual | input | 1 | 1 = two channels active, 0 = channel 0 only |
| cfg_shift | input | 4 | Gain shift amount, values above 8 act as 8 |
| flush | input | 1 | Synchronous discard of pending words, clears overrun |
| smp_valid | input | 1 | A sample set is present this cycle |
| smp_i0 | input | 16 | Channel 0 in-phase sample, signed |
| smp_q0 | input | 16 | Channel 0 quadrature sample, signed |
| smp_i1 | input | 16 | Channel 1 in-phase sample, signed |
| smp_q1 | input | 16 | Channel 1 quadrature sample, signed |
| pk_valid | output | 1 | Output word is valid |
| pk_ready | input | 1 | Downstream accepts the word |
| pk_data | output | 16 | Output word |
| ovr_flag | output | 1 | Sticky overrun indicator |

## Verification
Assertions check several properties on every cycle:
- the output holds under back-pressure;
- the overrun flag stays set until a flush;
- the word index stays inside the loaded burst;
- every gained sample keeps the sign of its input;
- a zero shift leaves the sample untouched.

Only the bench scenarios can show the actual word order and byte placement for each mode, and the saturated values at both rails. They also show that a configuration write leaves a pending burst in its old format. Finally, they show that a dropped set is truly absent from the output stream, and that a new set loads in the same cycle the last pending word leaves.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;
  localparam int SAMP_W    = 16;
  localparam int SHIFT_W   = 4;
  localparam int MAX_SHIFT = 8;
  localparam int NUM_CH    = 2;
  localparam int BYTE_W    = SAMP_W / 2;
  localparam int LANES     = 2 * NUM_CH;
  localparam int MAX_WORDS = LANES;
  localparam int CNT_W     = $clog2(MAX_WORDS + 1);
  localparam int IDX_W     = $clog2(MAX_WORDS);

  typedef struct packed {
    logic               narrow;
    logic               dual;
    logic [SHIFT_W-1:0] shift;
  } rxpk_cfg_t;
endpackage

// File: rtl/rxpk_gain.sv
module rxpk_gain #(
  parameter int SAMP_W    = 16,
  parameter int SHIFT_W   = 4,
  parameter int MAX_SHIFT = 8
) (
  input  logic [SAMP_W-1:0]  din,
  input  logic [SHIFT_W-1:0] shift,
  output logic [SAMP_W-1:0]  dout
);
  localparam int EXT_W = SAMP_W + MAX_SHIFT;
  localparam int TOP_W = MAX_SHIFT + 1;

  logic [SHIFT_W-1:0] amt;
  logic [EXT_W-1:0]   ext;
  logic [EXT_W-1:0]   shifted;
  logic [TOP_W-1:0]   top_bits;
  logic               fits;
  logic               neg;

  always_comb begin
    amt      = (int'(shift) > MAX_SHIFT) ? SHIFT_W'(MAX_SHIFT) : shift;
    neg      = din[SAMP_W-1];
    ext      = {{MAX_SHIFT{neg}}, din};
    shifted  = ext << amt;
    top_bits = shifted[EXT_W-1:SAMP_W-1];
    fits     = (&top_bits) | ~(|top_bits);
    if (fits) begin
      dout = shifted[SAMP_W-1:0];
    end else if (neg) begin
      dout = {1'b1, {(SAMP_W-1){1'b0}}};
    end else begin
      dout = {1'b0, {(SAMP_W-1){1'b1}}};
    end
  end
endmodule

// File: rtl/rxpk_frame.sv
module rxpk_frame
  import rxpk_pkg::*;
(
  input  logic [LANES-1:0][SAMP_W-1:0]     lanes,
  input  logic                             narrow,
  input  logic                             dual,
  output logic [MAX_WORDS-1:0][SAMP_W-1:0] words,
  output logic [CNT_W-1:0]                 nwords
);
  logic [NUM_CH-1:0][SAMP_W-1:0] packed_w;
  logic [CNT_W-1:0]              act_ch;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_pack
    assign packed_w[ch] = {lanes[2*ch+1][SAMP_W-1 -: BYTE_W],
                           lanes[2*ch][SAMP_W-1 -: BYTE_W]};
  end

  for (genvar k = 0; k < MAX_WORDS; k++) begin : g_word
    if (k < NUM_CH) begin : g_both
      assign words[k] = narrow ? packed_w[k] : lanes[k];
    end else begin : g_wide
      assign words[k] = narrow ? '0 : lanes[k];
    end
  end

  always_comb begin
    act_ch = dual ? CNT_W'(NUM_CH) : CNT_W'(1);
    nwords = narrow ? act_ch : CNT_W'(2 * int'(act_ch));
  end
endmodule

// File: rtl/rxpk_outbuf.sv
module rxpk_outbuf
  import rxpk_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             flush,
  input  logic                             in_valid,
  input  logic [MAX_WORDS-1:0][SAMP_W-1:0] words,
  input  logic [CNT_W-1:0]                 nwords,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic [SAMP_W-1:0]                out_data,
  output logic                             ovr
);
  logic [MAX_WORDS-1:0][SAMP_W-1:0] buf_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             ovr_q, ovr_d;
  logic             fire, last, can_load, load, buf_en;

  always_comb begin
    fire     = (cnt_q != '0) && out_ready;
    last     = fire && (CNT_W'(idx_q) == (cnt_q - CNT_W'(1)));
    can_load = (cnt_q == '0) || last;
    load     = in_valid && can_load && !flush;
    buf_en   = load;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    ovr_d    = ovr_q;
    if (fire) begin
      idx_d = idx_q + IDX_W'(1);
    end
    if (last) begin
      cnt_d = '0;
      idx_d = '0;
    end
    if (load) begin
      cnt_d = nwords;
      idx_d = '0;
    end
    if (in_valid && !can_load) begin
      ovr_d = 1'b1;
    end
    if (flush) begin
      cnt_d = '0;
      idx_d = '0;
      ovr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (buf_en) begin
      buf_q <= words;
    end
  end

  assign out_valid = (cnt_q != '0);
  assign out_data  = buf_q[idx_q];
  assign ovr       = ovr_q;

  // R9
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data)));

  // R10
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !flush) |=> ovr);

  // R10
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(in_valid && out_valid));

  // R11
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && !ovr));

  // R3
  idx_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (CNT_W'(idx_q) < cnt_q));
endmodule

// File: rtl/rxpk_top.sv
module rxpk_top
  import rxpk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_narrow,
  input  logic               cfg_dual,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic               flush,
  input  logic               smp_valid,
  input  logic [SAMP_W-1:0]  smp_i0,
  input  logic [SAMP_W-1:0]  smp_q0,
  input  logic [SAMP_W-1:0]  smp_i1,
  input  logic [SAMP_W-1:0]  smp_q1,
  output logic               pk_valid,
  input  logic               pk_ready,
  output logic [SAMP_W-1:0]  pk_data,
  output logic               ovr_flag
);
  rxpk_cfg_t cfg_q, cfg_d;
  logic      cfg_en;

  logic [LANES-1:0][SAMP_W-1:0]     raw;
  logic [LANES-1:0][SAMP_W-1:0]     gained;
  logic [MAX_WORDS-1:0][SAMP_W-1:0] words;
  logic [CNT_W-1:0]                 nwords;

  always_comb begin
    cfg_en        = cfg_we;
    cfg_d.narrow  = cfg_narrow;
    cfg_d.dual    = cfg_dual;
    cfg_d.shift   = cfg_shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign raw = {smp_q1, smp_i1, smp_q0, smp_i0};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    rxpk_gain #(
      .SAMP_W   (SAMP_W),
      .SHIFT_W  (SHIFT_W),
      .MAX_SHIFT(MAX_SHIFT)
    ) u_gain (
      .din  (raw[l]),
      .shift(cfg_q.shift),
      .dout (gained[l])
    );

    // R6
    sign_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gained[l][SAMP_W-1] == raw[l][SAMP_W-1]);

    // R2
    zero_shift_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.shift == '0) |-> (gained[l] == raw[l]));
  end

  rxpk_frame u_frame (
    .lanes (gained),
    .narrow(cfg_q.narrow),
    .dual  (cfg_q.dual),
    .words (words),
    .nwords(nwords)
  );

  rxpk_outbuf u_outbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .in_valid (smp_valid),
    .words    (words),
    .nwords   (nwords),
    .out_valid(pk_valid),
    .out_ready(pk_ready),
    .out_data (pk_data),
    .ovr      (ovr_flag)
  );
endmodule

// File: tb/tb_rxpk_top.sv
`timescale 1ns/1ps
module tb_rxpk_top;
  logic        clk;
  logic        rst_n;
  logic        cfg_we, cfg_narrow, cfg_dual;
  logic [3:0]  cfg_shift;
  logic        flush, smp_valid, pk_ready;
  logic [15:0] smp_i0, smp_q0, smp_i1, smp_q1;
  logic        pk_valid, ovr_flag;
  logic [15:0] pk_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  rxpk_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_narrow(cfg_narrow),
    .cfg_dual(cfg_dual), .cfg_shift(cfg_shift), .flush(flush),
    .smp_valid(smp_valid), .smp_i0(smp_i0), .smp_q0(smp_q0),
    .smp_i1(smp_i1), .smp_q1(smp_q1), .pk_valid(pk_valid),
    .pk_ready(pk_ready), .pk_data(pk_data), .ovr_flag(ovr_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [15:0] tag;
    logic        narrow;
    logic        dual;
    logic [3:0]  shift;
    logic [15:0] i0, q0, i1, q1;
    logic [15:0] e0, e1, e2, e3;
    logic [2:0]  n;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [0:NV-1] = '{
    '{"R2", 1'b0, 1'b0, 4'd0,  16'h1234, 16'hABCD, 16'h0000, 16'h0000,
      16'h1234, 16'hABCD, 16'h0000, 16'h0000, 3'd2},
    '{"R3", 1'b0, 1'b1, 4'd0,  16'h0001, 16'h8000, 16'h7FFF, 16'hFFFF,
      16'h0001, 16'h8000, 16'h7FFF, 16'hFFFF, 3'd4},
    '{"R4", 1'b1, 1'b0, 4'd0,  16'h1234, 16'hABCD, 16'h0000, 16'h0000,
      16'hAB12, 16'h0000, 16'h0000, 16'h0000, 3'd1},
    '{"R5", 1'b1, 1'b1, 4'd0,  16'h7F00, 16'h80FF, 16'h0100, 16'hFE00,
      16'h807F, 16'hFE01, 16'h0000, 16'h0000, 3'd2},
    '{"R6", 1'b0, 1'b0, 4'd4,  16'h0123, 16'hFFF0, 16'h0000, 16'h0000,
      16'h1230, 16'hFF00, 16'h0000, 16'h0000, 3'd2},
    '{"R7", 1'b0, 1'b0, 4'd2,  16'h2001, 16'hC000, 16'h0000, 16'h0000,
      16'h7FFF, 16'h8000, 16'h0000, 16'h0000, 3'd2},
    '{"R6", 1'b1, 1'b0, 4'd8,  16'h0012, 16'hFFFE, 16'h0000, 16'h0000,
      16'hFE12, 16'h0000, 16'h0000, 16'h0000, 3'd1},
    '{"R8", 1'b1, 1'b0, 4'd15, 16'h0080, 16'hFF80, 16'h0000, 16'h0000,
      16'h807F, 16'h0000, 16'h0000, 16'h0000, 3'd1},
    '{"R7", 1'b1, 1'b1, 4'd1,  16'h4000, 16'hE001, 16'h0011, 16'h1234,
      16'hC07F, 16'h2400, 16'h0000, 16'h0000, 3'd2}
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_cfg(logic nar, logic dua, logic [3:0] sh);
    @(negedge clk);
    cfg_we = 1'b1; cfg_narrow = nar; cfg_dual = dua; cfg_shift = sh;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(logic [15:0] a, logic [15:0] b, logic [15:0] c, logic [15:0] d);
    @(negedge clk);
    smp_valid = 1'b1; smp_i0 = a; smp_q0 = b; smp_i1 = c; smp_q1 = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic expect_word(string req, logic [15:0] exp);
    check(req, {15'd0, pk_valid}, 16'd1);
    check(req, pk_data, exp);
    @(negedge clk);
  endtask

  task automatic expect_idle(string req);
    check(req, {15'd0, pk_valid}, 16'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_narrow = 1'b0; cfg_dual = 1'b0;
    cfg_shift = 4'd0; flush = 1'b0; smp_valid = 1'b0; pk_ready = 1'b1;
    smp_i0 = '0; smp_q0 = '0; smp_i1 = '0; smp_q1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state and default configuration
    check("R1", {15'd0, pk_valid}, 16'd0);
    check("R1", {15'd0, ovr_flag}, 16'd0);
    send(16'h5A5A, 16'hA5A5, 16'h1111, 16'h2222);
    expect_word("R1", 16'h5A5A);
    expect_word("R1", 16'hA5A5);
    expect_idle("R1");

    // table of mode / shift vectors
    for (int v = 0; v < NV; v++) begin
      write_cfg(VECS[v].narrow, VECS[v].dual, VECS[v].shift);
      send(VECS[v].i0, VECS[v].q0, VECS[v].i1, VECS[v].q1);
      for (int w = 0; w < int'(VECS[v].n); w++) begin
        logic [15:0] e;
        case (w)
          0: e = VECS[v].e0;
          1: e = VECS[v].e1;
          2: e = VECS[v].e2;
          default: e = VECS[v].e3;
        endcase
        expect_word(string'(VECS[v].tag), e);
      end
      expect_idle(string'(VECS[v].tag));
    end

    // R9: stall holds word 0 of a wide dual burst
    write_cfg(1'b0, 1'b1, 4'd0);
    pk_ready = 1'b0;
    send(16'h0101, 16'h0202, 16'h0303, 16'h0404);
    for (int k = 0; k < 3; k++) begin
      check("R9", {15'd0, pk_valid}, 16'd1);
      check("R9", pk_data, 16'h0101);
      @(negedge clk);
    end
    pk_ready = 1'b1;
    expect_word("R9", 16'h0101);
    expect_word("R9", 16'h0202);
    expect_word("R9", 16'h0303);
    expect_word("R9", 16'h0404);
    expect_idle("R9");

    // R10: a set arriving while busy is dropped and flags overrun
    write_cfg(1'b0, 1'b0, 4'd0);
    pk_ready = 1'b0;
    send(16'h0A0A, 16'h0B0B, 16'h0, 16'h0);
    check("R10", {15'd0, ovr_flag}, 16'd0);
    send(16'hFFFF, 16'hEEEE, 16'h0, 16'h0);
    check("R10", {15'd0, ovr_flag}, 16'd1);
    pk_ready = 1'b1;
    expect_word("R10", 16'h0A0A);
    expect_word("R10", 16'h0B0B);
    expect_idle("R10");
    check("R10", {15'd0, ovr_flag}, 16'd1);

    // R11: flush discards pending words and clears overrun
    pk_ready = 1'b0;
    send(16'h1357, 16'h2468, 16'h0, 16'h0);
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check("R11", {15'd0, pk_valid}, 16'd0);
    check("R11", {15'd0, ovr_flag}, 16'd0);

    // R12: config write leaves a pending burst in its old format
    send(16'h1111, 16'h2222, 16'h0, 16'h0);
    write_cfg(1'b1, 1'b0, 4'd0);
    pk_ready = 1'b1;
    expect_word("R12", 16'h1111);
    expect_word("R12", 16'h2222);
    expect_idle("R12");
    send(16'h3344, 16'h5566, 16'h0, 16'h0);
    expect_word("R12", 16'h5533);
    expect_idle("R12");

    // R13: back-to-back narrow sets, last word leaves as next loads
    @(negedge clk);
    smp_valid = 1'b1; smp_i0 = 16'h1200; smp_q0 = 16'h3400;
    @(negedge clk);
    smp_i0 = 16'h5600; smp_q0 = 16'h7800;
    check("R13", {15'd0, pk_valid}, 16'd1);
    check("R13", pk_data, 16'h3412);
    @(negedge clk);
    smp_valid = 1'b0;
    check("R13", {15'd0, pk_valid}, 16'd1);
    check("R13", pk_data, 16'h7856);
    check("R13", {15'd0, ovr_flag}, 16'd0);
    @(negedge clk);
    expect_idle("R13");

    done = 1;
    summary();
    $finish;
  end
endmodule